// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a sum-of-products logic device. A group of product terms arriving from an AND plane is ORed into a single sum. Any of a group-wide pool of shared expander terms can be added to that sum. A configuration bit can invert the result. The result then feeds a storage element, which can hold it or toggle on it. The pin can carry either the stored value or the combinational value. A second selector chooses which value goes back into the array as feedback.

All behaviour is set by static configuration inputs. In synchronous mode the storage element runs from the global clock, and the local term gates the pin driver. In asynchronous mode the local term becomes the storage clock, and the pin is always driven. The active clock edge can be rising or falling in either mode. A dedicated clear term empties the storage element at once. The pin enable stands for a three-state driver: when it is low, the pin is high-impedance.

Top module: `cpld_macrocell`

## Requirements
- R1: The sum is the OR of all `NUM_PT` product terms and of every expander term whose bit in `exp_sel` is 1. An expander term whose select bit is 0 has no effect.
- R2: With `cfg_invert`=1, the cell value is the sum inverted. With `cfg_invert`=0, it is the sum unchanged.
- R3: With `cfg_reg_out`=1, `pin_out` shows the storage element. With `cfg_reg_out`=0, it shows the cell value directly, with no clock delay.
- R4: With `cfg_fb_pin`=1, `fb_out` equals `pin_out`. With `cfg_fb_pin`=0, it equals the storage element.
- R5: With `cfg_async`=0, the storage element updates on `clk` and `pin_oe` follows `local_term`.
- R6: With `cfg_async`=1, the storage element updates on `local_term` and `pin_oe` is 1.
- R7: With `cfg_toggle`=0, the storage element loads the cell value on an active edge. With `cfg_toggle`=1, it inverts when the cell value is 1 and holds when it is 0.
- R8: With `cfg_negedge`=0, the active edge is the rising edge of the selected clock. With `cfg_negedge`=1, it is the falling edge.
- R9: While `clr_term` is 1, the storage element is 0 at once, whatever the clocks do.
- R10: While `rst` is 1, the storage element is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst | input | 1 | Active-high reset, clears the storage element |
| pterm | input | NUM_PT | Product terms from the AND plane |
| exp_term | input | NUM_EXP | Shared expander terms of the group |
| exp_sel | input | NUM_EXP | Per-expander enable into this cell's sum |
| local_term | input | 1 | Output enable (synchronous mode) or storage clock (asynchronous mode) |
| clr_term | input | 1 | Clear product term, active high |
| cfg_async | input | 1 | 1 selects asynchronous mode |
| cfg_toggle | input | 1 | 1 selects toggle storage, 0 selects data storage |
| cfg_negedge | input | 1 | 1 selects the falling clock edge |
| cfg_invert | input | 1 | 1 inverts the sum |
| cfg_reg_out | input | 1 | 1 sends the stored value to the pin |
| cfg_fb_pin | input | 1 | 1 feeds the pin value back, 0 feeds the stored value back |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin driver enable; low means high-impedance |
| fb_out | output | 1 | Feedback into the array |

## Verification
The bench builds the cell with eight product terms and four expanders. With only four expanders, sparse random terms and random select masks often leave the sum at 0. This means an unselected expander holding a 1 is frequently the only thing that could raise the sum, so R1's masking is really exercised. The bench drives data a quarter period after the rising clock edge and moves the local term half a period after that edge. As a result, both edges of the global clock and both edges of the local clock can be active without racing the data. Mode and edge switches are made only while the clear term is held.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    typedef struct packed {
        logic async_clk;
        logic toggle;
        logic neg_edge;
        logic invert;
        logic reg_out;
        logic fb_pin;
    } cell_cfg_t;

    typedef enum logic {
        STORE_DATA   = 1'b0,
        STORE_TOGGLE = 1'b1
    } store_kind_e;

    function automatic logic store_next(store_kind_e kind, logic cur, logic din);
        return (kind == STORE_TOGGLE) ? (cur ^ din) : din;
    endfunction

endpackage

// File: rtl/mc_sum.sv
module mc_sum #(
    parameter int NUM_PT  = 8,
    parameter int NUM_EXP = 32
) (
    input  logic [NUM_PT-1:0]  pterm,
    input  logic [NUM_EXP-1:0] exp_term,
    input  logic [NUM_EXP-1:0] exp_sel,
    input  logic               invert,
    output logic               cell_val
);
    localparam int NUM_IN = NUM_PT + NUM_EXP;

    logic [NUM_IN-1:0] gated;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_term
        if (i < NUM_PT) begin : g_pt
            assign gated[i] = pterm[i];
        end else begin : g_exp
            assign gated[i] = exp_term[i-NUM_PT] & exp_sel[i-NUM_PT];
        end
    end

    assign cell_val = (|gated) ^ invert;
endmodule

// File: rtl/mc_store.sv
module mc_store
    import mcell_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      local_term,
    input  logic      clr_term,
    input  cell_cfg_t cfg,
    input  logic      cell_val,
    output logic      q
);
    logic        clk_src;
    logic        clk_eff;
    logic        clr_any;
    store_kind_e kind;

    assign clk_src = cfg.async_clk ? local_term : clk;
    assign clk_eff = clk_src ^ cfg.neg_edge;
    assign clr_any = clr_term | rst;
    assign kind    = cfg.toggle ? STORE_TOGGLE : STORE_DATA;

    always_ff @(posedge clk_eff or posedge clr_any) begin
        if (clr_any) q <= 1'b0;
        else         q <= store_next(kind, q, cell_val);
    end

    AST_D_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!cfg.async_clk && !cfg.neg_edge && !cfg.toggle && !clr_term)
        |=> (clr_term || q == $past(cell_val)));           // R7

    AST_T_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (!cfg.async_clk && !cfg.neg_edge && cfg.toggle && !clr_term)
        |=> (clr_term || q == ($past(q) ^ $past(cell_val)))); // R7

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_term |-> (q == 1'b0));                         // R9
endmodule

// File: rtl/mc_route.sv
module mc_route
    import mcell_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_cfg_t cfg,
    input  logic      cell_val,
    input  logic      q,
    input  logic      local_term,
    output logic      pin_out,
    output logic      pin_oe,
    output logic      fb_out
);
    always_comb begin
        pin_out = cfg.reg_out ? q : cell_val;
        pin_oe  = cfg.async_clk | local_term;
        fb_out  = cfg.fb_pin ? pin_out : q;
    end

    AST_FB_PIN: assert property (@(posedge clk) disable iff (rst)
        cfg.fb_pin |-> (fb_out == pin_out));               // R4

    AST_OE_SYNC: assert property (@(posedge clk) disable iff (rst)
        !cfg.async_clk |-> (pin_oe == local_term));        // R5

    AST_OE_ASYNC: assert property (@(posedge clk) disable iff (rst)
        cfg.async_clk |-> pin_oe);                         // R6
endmodule

// File: rtl/cpld_macrocell.sv
module cpld_macrocell
    import mcell_pkg::*;
#(
    parameter int NUM_PT  = 8,
    parameter int NUM_EXP = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_PT-1:0]  pterm,
    input  logic [NUM_EXP-1:0] exp_term,
    input  logic [NUM_EXP-1:0] exp_sel,
    input  logic               local_term,
    input  logic               clr_term,
    input  logic               cfg_async,
    input  logic               cfg_toggle,
    input  logic               cfg_negedge,
    input  logic               cfg_invert,
    input  logic               cfg_reg_out,
    input  logic               cfg_fb_pin,
    output logic               pin_out,
    output logic               pin_oe,
    output logic               fb_out
);
    cell_cfg_t cfg;
    logic      cell_val;
    logic      q;

    assign cfg = '{async_clk: cfg_async, toggle: cfg_toggle, neg_edge: cfg_negedge,
                   invert: cfg_invert, reg_out: cfg_reg_out, fb_pin: cfg_fb_pin};

    mc_sum #(.NUM_PT(NUM_PT), .NUM_EXP(NUM_EXP)) u_sum (
        .pterm    (pterm),
        .exp_term (exp_term),
        .exp_sel  (exp_sel),
        .invert   (cfg.invert),
        .cell_val (cell_val)
    );

    mc_store u_store (
        .clk        (clk),
        .rst        (rst),
        .local_term (local_term),
        .clr_term   (clr_term),
        .cfg        (cfg),
        .cell_val   (cell_val),
        .q          (q)
    );

    mc_route u_route (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .cell_val   (cell_val),
        .q          (q),
        .local_term (local_term),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .fb_out     (fb_out)
    );
endmodule

// File: tb/cpld_macrocell_tb_top.sv
module cpld_macrocell_tb_top;
    localparam int NPT = 8;
    localparam int NEX = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic [NPT-1:0] pterm;
    logic [NEX-1:0] exp_term, exp_sel;
    logic           local_term, clr_term;
    logic           cfg_async, cfg_toggle, cfg_negedge, cfg_invert, cfg_reg_out, cfg_fb_pin;
    logic           pin_out, pin_oe, fb_out;

    int checks = 0;
    int errors = 0;
    bit m_q = 1'b0;

    always #2 clk = ~clk;

    cpld_macrocell #(.NUM_PT(NPT), .NUM_EXP(NEX)) dut_i (
        .clk(clk), .rst(rst), .pterm(pterm), .exp_term(exp_term), .exp_sel(exp_sel),
        .local_term(local_term), .clr_term(clr_term),
        .cfg_async(cfg_async), .cfg_toggle(cfg_toggle), .cfg_negedge(cfg_negedge),
        .cfg_invert(cfg_invert), .cfg_reg_out(cfg_reg_out), .cfg_fb_pin(cfg_fb_pin),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    // Reference: cell value from the requirements (R1, R2)
    function automatic bit ref_cell();
        bit s = 1'b0;
        for (int i = 0; i < NPT; i++) if (pterm[i]) s = 1'b1;
        for (int i = 0; i < NEX; i++) if (exp_term[i] && exp_sel[i]) s = 1'b1;
        return s ^ cfg_invert;
    endfunction

    function automatic bit ref_next(bit cur);
        return cfg_toggle ? (cur ^ ref_cell()) : ref_cell();
    endfunction

    task automatic check(string tag, logic got, bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // One global clock period. Data at +1, local term at +2, compare at +3.
    task automatic cyc(string tag, bit new_local);
        bit old_eff, new_eff, rp;
        @(posedge clk);
        if (!cfg_async && !cfg_negedge && !clr_term && !rst) m_q = ref_next(m_q); // R5 R8
        #1;
        pterm    = NPT'($urandom & $urandom & $urandom);
        exp_term = NEX'($urandom);
        exp_sel  = NEX'($urandom);
        if (clr_term || rst) m_q = 1'b0;                                          // R9 R10
        #1;
        old_eff    = local_term ^ cfg_negedge;
        local_term = new_local;
        new_eff    = local_term ^ cfg_negedge;
        if (!clr_term && !rst) begin
            if (cfg_async && !old_eff && new_eff) m_q = ref_next(m_q);            // R6
            else if (!cfg_async && cfg_negedge) m_q = ref_next(m_q);              // R8
        end
        #1;
        rp = cfg_reg_out ? m_q : ref_cell();
        check({tag, " pin"}, pin_out, rp);
        check({tag, " oe"},  pin_oe, cfg_async ? 1'b1 : local_term);
        check({tag, " fb"},  fb_out, cfg_fb_pin ? rp : m_q);
    endtask

    task automatic phase(string tag, int n, bit local_clocks);
        for (int k = 0; k < n; k++)
            cyc(tag, local_clocks ? bit'(k % 2) : bit'($urandom_range(0, 1)));
    endtask

    // Change clock mode only while clear is held, so no spurious edge counts.
    task automatic set_clocking(bit a, bit ne);
        @(posedge clk); #1;
        clr_term = 1'b1; m_q = 1'b0;
        @(posedge clk); #1;
        cfg_async = a; cfg_negedge = ne; local_term = 1'b0;
        @(posedge clk); #1;
        clr_term = 1'b0;
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; clr_term = 1'b0; local_term = 1'b0;
        pterm = '0; exp_term = '0; exp_sel = '0;
        cfg_async = 1'b0; cfg_toggle = 1'b0; cfg_negedge = 1'b0;
        cfg_invert = 1'b1; cfg_reg_out = 1'b1; cfg_fb_pin = 1'b0;
        phase("R10 reset", 4, 1'b0);
        rst = 1'b0;

        phase("R1 R7 sync D registered", 40, 1'b0);
        cfg_invert = 1'b0;
        phase("R2 no invert", 30, 1'b0);
        cfg_reg_out = 1'b0;
        phase("R3 R1 comb path expander select", 40, 1'b0);
        cfg_invert = 1'b1;
        phase("R2 R3 comb inverted", 30, 1'b0);
        cfg_fb_pin = 1'b1;
        phase("R4 feedback from pin comb", 30, 1'b0);
        cfg_reg_out = 1'b1;
        phase("R4 feedback from pin reg", 30, 1'b0);
        cfg_fb_pin = 1'b0; cfg_reg_out = 1'b0;
        phase("R4 feedback from reg", 30, 1'b0);
        cfg_reg_out = 1'b1; cfg_toggle = 1'b1;
        phase("R7 toggle rising", 40, 1'b0);

        set_clocking(1'b0, 1'b1);
        phase("R8 sync falling toggle", 30, 1'b0);
        cfg_toggle = 1'b0;
        phase("R8 sync falling data", 30, 1'b0);

        set_clocking(1'b1, 1'b0);
        phase("R6 async rising data", 40, 1'b1);
        cfg_toggle = 1'b1;
        phase("R6 R7 async rising toggle", 30, 1'b1);
        set_clocking(1'b1, 1'b1);
        phase("R6 R8 async falling toggle", 30, 1'b1);
        cfg_toggle = 1'b0;
        phase("R6 R8 async falling data", 30, 1'b1);

        // Clear pulses in asynchronous mode while local clocks keep running
        for (int r = 0; r < 6; r++) begin
            phase("R6 async pre-clear", 3, 1'b1);
            @(posedge clk); #1; clr_term = 1'b1; m_q = 1'b0;
            phase("R9 clear holds async", 4, 1'b1);
            clr_term = 1'b0;
        end

        set_clocking(1'b0, 1'b0);
        cfg_toggle = 1'b1;
        for (int r = 0; r < 6; r++) begin
            phase("R5 sync pre-clear", 3, 1'b0);
            @(posedge clk); #1; clr_term = 1'b1; m_q = 1'b0;
            phase("R9 clear holds sync", 4, 1'b0);
            clr_term = 1'b0;
        end

        rst = 1'b1;
        phase("R10 reset mid-run", 3, 1'b0);
        rst = 1'b0;
        phase("R5 sync after reset", 20, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule